// File: doc/BRIEF.md
# Barrel Shifter with Condition Flags

This block shifts a 32-bit word left logically, right logically or right arithmetically. The number of places comes from a count input. It also works out the five condition flags that go with the result. A consumer presents an operand, a count, a 2-bit kind selector and the current extend flag, and raises a one-cycle strobe. One clock later the registered result and flags appear, together with a one-cycle valid pulse.

Counts are taken modulo 64, so the flags are defined for counts that meet or pass the word width. A left shift by 32 leaves a zero word, and the carry is the lowest operand bit. Left or logical right shifts by 33 or more clear the carry. An arithmetic right shift by 33 or more copies the sign bit into both the result and the carry. A zero count clears the carry and leaves the extend flag as it came in. The selector code 3 is held back: it passes the operand through and keeps every flag at its previous value.

Top module: `shift_cc_unit`

## Requirements
- R1: Only the low 6 bits of `inCount` choose the shift amount (0..63); the bits above them have no effect on the result or the flags.
- R2: With `inKind` = 2'b00 (logical left), the result is the low 32 bits of the operand shifted left. Carry is the last bit pushed past bit 31: operand bit 32-n for counts n of 1..32, and 0 for counts of 33 or more.
- R3: With `inKind` = 2'b01 (logical right), zeros fill from the top. Carry is operand bit n-1 for counts n of 1..32, and 0 for counts of 33 or more. Any count of 32 or more gives a zero result.
- R4: With `inKind` = 2'b10 (arithmetic right), copies of operand bit 31 fill from the top. Carry is operand bit n-1 for counts n of 1..32, and operand bit 31 for counts of 33 or more. Any count of 32 or more gives a result made only of sign copies.
- R5: For a nonzero count the extend flag equals the new carry. For a zero count it equals the `inExtend` that was presented.
- R6: A zero count returns the operand unchanged and clears the carry.
- R7: Overflow is 0 for both logical kinds. For the arithmetic kind it is bit 31 of the result XOR bit 31 of the operand.
- R8: Negative equals bit 31 of the result. Zero is 1 exactly when all 32 result bits are 0.
- R9: `inKind` = 2'b11 is reserved. The result becomes the operand, and all five flags keep their previous values.
- R10: The result, the flags and `outValid` are updated on the edge that samples `inValid` high. `outValid` is high for that one cycle only. Without a strobe, the result and the flags hold.
- R11: While `rstN` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| inValid | input | 1 | Strobe: operation presented this cycle |
| inOperand | input | 32 | Word to shift |
| inCount | input | 8 | Shift count; low 6 bits used |
| inKind | input | 2 | 00 lsl, 01 lsr, 10 asr, 11 reserved |
| inExtend | input | 1 | Current extend flag |
| outValid | output | 1 | One-cycle pulse with a new result |
| outResult | output | 32 | Shifted word |
| outCarry | output | 1 | Carry flag |
| outExtend | output | 1 | Extend flag |
| outNeg | output | 1 | Negative flag |
| outZero | output | 1 | Zero flag |
| outOvf | output | 1 | Overflow flag |

## Verification
There is a single pipeline register. A wrong internal state therefore shows up on the ports in the very cycle after the strobe: a bad result, a bad flag, or a missing valid pulse. The exceptions are flags that a reserved operation leaves in place; a stale or corrupted flag held there is only seen on the next reserved operation or by comparison across cycles. For that reason the corner counts 0, 1, 31, 32, 33 and 63 are each checked with operand bit patterns in which the expected carry bit differs from its neighbours. Reserved operations are placed straight after known flag states.

// File: rtl/shift_cc_pkg.sv
package shift_cc_pkg;

  typedef enum logic [1:0] {
    KIND_LSL = 2'b00,
    KIND_LSR = 2'b01,
    KIND_ASR = 2'b10,
    KIND_RSV = 2'b11
  } shiftKindE;

  typedef struct packed {
    logic      capture;
    logic      updFlags;
    shiftKindE kind;
  } ctrlStrobeT;

  typedef struct packed {
    logic x;
    logic n;
    logic z;
    logic v;
    logic c;
  } ccFlagsT;

endpackage

// File: rtl/shift_cc_ctrl.sv
module shift_cc_ctrl
  import shift_cc_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       inValid,
  input  logic [1:0] inKind,
  output ctrlStrobeT strobes,
  output logic       validQ
);

  shiftKindE kindDec;

  always_comb begin
    kindDec          = shiftKindE'(inKind);
    strobes.kind     = kindDec;
    strobes.capture  = inValid;
    strobes.updFlags = inValid && (kindDec != KIND_RSV);
  end

  always_ff @(posedge clk) begin
    if (!rstN) validQ <= 1'b0;
    else       validQ <= inValid;
  end

endmodule

// File: rtl/shift_cc_datapath.sv
module shift_cc_datapath
  import shift_cc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  ctrlStrobeT          strobes,
  input  logic [DATA_W-1:0]   operand,
  input  logic [CNT_IN_W-1:0] count,
  input  logic                extendIn,
  output logic [DATA_W-1:0]   resultQ,
  output ccFlagsT             flagsQ
);

  localparam int SPAN  = 2 * DATA_W;
  localparam int SH_W  = $clog2(SPAN);

  logic [SH_W-1:0]          shAmt;
  logic [DATA_W:0]          lslWide;
  logic [DATA_W:0]          lsrWide;
  logic signed [DATA_W:0]   asrSrc;
  logic signed [DATA_W:0]   asrWide;
  logic [DATA_W-1:0]        resNext;
  logic                     carryNext;
  logic                     ovfNext;
  ccFlagsT                  flagsNext;

  always_comb begin
    shAmt   = SH_W'(count % CNT_IN_W'(SPAN));
    lslWide = {1'b0, operand} << shAmt;
    lsrWide = {operand, 1'b0} >> shAmt;
    asrSrc  = {operand, 1'b0};
    asrWide = asrSrc >>> shAmt;

    resNext   = operand;
    carryNext = 1'b0;
    ovfNext   = 1'b0;
    case (strobes.kind)
      KIND_LSL: begin
        resNext   = lslWide[DATA_W-1:0];
        carryNext = lslWide[DATA_W];
      end
      KIND_LSR: begin
        resNext   = lsrWide[DATA_W:1];
        carryNext = lsrWide[0];
      end
      KIND_ASR: begin
        resNext   = asrWide[DATA_W:1];
        carryNext = asrWide[0];
        ovfNext   = asrWide[DATA_W] ^ operand[DATA_W-1];
      end
      default: begin
        resNext   = operand;
        carryNext = 1'b0;
      end
    endcase

    flagsNext.c = carryNext;
    flagsNext.x = (shAmt != '0) ? carryNext : extendIn;
    flagsNext.n = resNext[DATA_W-1];
    flagsNext.z = (resNext == '0);
    flagsNext.v = ovfNext;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      resultQ <= '0;
      flagsQ  <= '0;
    end else begin
      if (strobes.capture)  resultQ <= resNext;
      if (strobes.updFlags) flagsQ  <= flagsNext;
    end
  end

endmodule

// File: rtl/shift_cc_unit.sv
module shift_cc_unit
  import shift_cc_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                inValid,
  input  logic [DATA_W-1:0]   inOperand,
  input  logic [CNT_IN_W-1:0] inCount,
  input  logic [1:0]          inKind,
  input  logic                inExtend,
  output logic                outValid,
  output logic [DATA_W-1:0]   outResult,
  output logic                outCarry,
  output logic                outExtend,
  output logic                outNeg,
  output logic                outZero,
  output logic                outOvf
);

  ctrlStrobeT strobes;
  ccFlagsT    flagsQ;

  shift_cc_ctrl u_ctrl (
    .clk     (clk),
    .rstN    (rstN),
    .inValid (inValid),
    .inKind  (inKind),
    .strobes (strobes),
    .validQ  (outValid)
  );

  shift_cc_datapath #(
    .DATA_W   (DATA_W),
    .CNT_IN_W (CNT_IN_W)
  ) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .strobes  (strobes),
    .operand  (inOperand),
    .count    (inCount),
    .extendIn (inExtend),
    .resultQ  (outResult),
    .flagsQ   (flagsQ)
  );

  assign outCarry  = flagsQ.c;
  assign outExtend = flagsQ.x;
  assign outNeg    = flagsQ.n;
  assign outZero   = flagsQ.z;
  assign outOvf    = flagsQ.v;

endmodule

// File: rtl/shift_cc_checker.sv
module shift_cc_checker #(
  parameter int DATA_W   = 32,
  parameter int CNT_IN_W = 8
) (
  input logic                clk,
  input logic                rstN,
  input logic                inValid,
  input logic [DATA_W-1:0]   inOperand,
  input logic [CNT_IN_W-1:0] inCount,
  input logic [1:0]          inKind,
  input logic                inExtend,
  input logic                outValid,
  input logic [DATA_W-1:0]   outResult,
  input logic                outCarry,
  input logic                outExtend,
  input logic                outNeg,
  input logic                outZero,
  input logic                outOvf
);

  // R10: valid pulse follows the strobe by one edge
  a_r10_valid_pulse: assert property (@(posedge clk) disable iff (!rstN)
    outValid == $past(inValid));

  // R10: no strobe, result held
  a_r10_hold: assert property (@(posedge clk) disable iff (!rstN)
    !outValid |-> $stable(outResult));

  // R8: zero and negative agree with the result after a real shift
  a_r8_flags_track: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inKind) != 2'b11) |->
      (outZero == (outResult == '0)) && (outNeg == outResult[DATA_W-1]));

  // R7: logical kinds never report overflow
  a_r7_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inKind[1]) == 1'b0) |-> !outOvf);

  // R6 and R5: zero count leaves operand, clears carry, passes extend
  a_r6_zero_count: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inKind) != 2'b11 && $past(inCount[5:0]) == 6'd0) |->
      (!outCarry && outExtend == $past(inExtend) && outResult == $past(inOperand)));

  // R9: reserved kind keeps all flags
  a_r9_reserved_flags: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(inKind) == 2'b11) |->
      ($stable(outCarry) && $stable(outExtend) && $stable(outNeg)
       && $stable(outZero) && $stable(outOvf)
       && outResult == $past(inOperand)));

endmodule

bind shift_cc_unit shift_cc_checker #(
  .DATA_W   (DATA_W),
  .CNT_IN_W (CNT_IN_W)
) i_chk (
  .clk       (clk),
  .rstN      (rstN),
  .inValid   (inValid),
  .inOperand (inOperand),
  .inCount   (inCount),
  .inKind    (inKind),
  .inExtend  (inExtend),
  .outValid  (outValid),
  .outResult (outResult),
  .outCarry  (outCarry),
  .outExtend (outExtend),
  .outNeg    (outNeg),
  .outZero   (outZero),
  .outOvf    (outOvf)
);

// File: tb/test_shift_cc_unit.sv
module test_shift_cc_unit;

  localparam int CLK_PERIOD = 10;
  localparam int TIMEOUT    = 5000;
  localparam int NVEC       = 15;
  localparam int VEC_W      = 80;

  // fields: kind(2) count(8) ext(1) operand(32) expResult(32) expFlags{x,n,z,v,c}(5)
  localparam logic [VEC_W-1:0] VECS [NVEC] = '{
    {2'b00, 8'd1,  1'b0, 32'h80000001, 32'h00000002, 5'b10001}, // R2
    {2'b00, 8'd31, 1'b0, 32'h00000001, 32'h80000000, 5'b01000}, // R2
    {2'b00, 8'd32, 1'b0, 32'h00000001, 32'h00000000, 5'b10101}, // R2
    {2'b00, 8'd33, 1'b1, 32'hFFFFFFFF, 32'h00000000, 5'b00100}, // R2
    {2'b01, 8'd1,  1'b0, 32'h80000001, 32'h40000000, 5'b10001}, // R3
    {2'b01, 8'd32, 1'b0, 32'h80000000, 32'h00000000, 5'b10101}, // R3
    {2'b01, 8'd40, 1'b1, 32'hFFFFFFFF, 32'h00000000, 5'b00100}, // R3
    {2'b10, 8'd4,  1'b1, 32'h80000000, 32'hF8000000, 5'b01000}, // R4
    {2'b10, 8'd33, 1'b0, 32'h80000000, 32'hFFFFFFFF, 5'b11001}, // R4
    {2'b10, 8'd63, 1'b1, 32'h7FFFFFFF, 32'h00000000, 5'b00100}, // R4
    {2'b10, 8'd2,  1'b0, 32'h00000006, 32'h00000001, 5'b10001}, // R4
    {2'b00, 8'd0,  1'b1, 32'h12345678, 32'h12345678, 5'b10000}, // R6 R5
    {2'b00, 8'h41, 1'b0, 32'h00000001, 32'h00000002, 5'b00000}, // R1
    {2'b10, 8'd0,  1'b0, 32'h80000000, 32'h80000000, 5'b01000}, // R6
    {2'b10, 8'd32, 1'b0, 32'hC0000000, 32'hFFFFFFFF, 5'b11001}  // R4
  };

  logic        clk = 1'b0;
  logic        rstN;
  logic        inValid;
  logic [31:0] inOperand;
  logic [7:0]  inCount;
  logic [1:0]  inKind;
  logic        inExtend;
  logic        outValid;
  logic [31:0] outResult;
  logic        outCarry, outExtend, outNeg, outZero, outOvf;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shift_cc_unit i_shift_cc_unit (
    .clk(clk), .rstN(rstN), .inValid(inValid), .inOperand(inOperand),
    .inCount(inCount), .inKind(inKind), .inExtend(inExtend),
    .outValid(outValid), .outResult(outResult), .outCarry(outCarry),
    .outExtend(outExtend), .outNeg(outNeg), .outZero(outZero), .outOvf(outOvf)
  );

  function automatic logic [4:0] flagsNow();
    return {outExtend, outNeg, outZero, outOvf, outCarry};
  endfunction

  task automatic check(input bit ok, input string req,
                       input logic [63:0] act, input logic [63:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic apply(input logic [1:0] k, input logic [7:0] c,
                       input logic x, input logic [31:0] op);
    @(negedge clk);
    inKind = k; inCount = c; inExtend = x; inOperand = op; inValid = 1'b1;
    @(negedge clk);
    inValid = 1'b0;
  endtask

  initial begin
    rstN = 1'b0; inValid = 1'b0; inOperand = '0; inCount = '0;
    inKind = '0; inExtend = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    check({outValid, outResult, flagsNow()} == '0, "R11",
          {26'd0, outValid, outResult, flagsNow()}, 64'd0);
    rstN = 1'b1;

    for (int i = 0; i < NVEC; i++) begin
      logic [VEC_W-1:0] v;
      v = VECS[i];
      apply(v[79:78], v[77:70], v[69], v[68:37]);
      check(outValid == 1'b1, "R10", outValid, 1);
      check(outResult == v[36:5], "R2/R3/R4 R1 R6 result", outResult, v[36:5]);
      check(flagsNow() == v[4:0], "R5 R7 R8 flags", flagsNow(), v[4:0]);
    end

    // R10: valid is a single pulse and outputs hold with no strobe
    apply(2'b01, 8'd4, 1'b0, 32'h000000F0);
    check(outResult == 32'h0000000F, "R3", outResult, 32'h0000000F);
    inOperand = 32'hAAAA5555; inCount = 8'd7; inKind = 2'b00;
    @(negedge clk);
    check(outValid == 1'b0, "R10 pulse", outValid, 0);
    @(negedge clk);
    check(outResult == 32'h0000000F && flagsNow() == 5'b00000, "R10 hold",
          {outResult, flagsNow()}, {32'h0000000F, 5'b00000});

    // R9: reserved kind after a known flag state 11001
    apply(2'b10, 8'd33, 1'b0, 32'h80000000);
    check(flagsNow() == 5'b11001, "R4", flagsNow(), 5'b11001);
    apply(2'b11, 8'd5, 1'b0, 32'hDEADBEEF);
    check(outResult == 32'hDEADBEEF, "R9 result", outResult, 32'hDEADBEEF);
    check(flagsNow() == 5'b11001, "R9 flags", flagsNow(), 5'b11001);

    // R1: high count bits ignored (8'hC0 -> 0 count)
    apply(2'b01, 8'hC0, 1'b1, 32'h00000003);
    check(outResult == 32'h3 && flagsNow() == 5'b10000, "R1",
          {outResult, flagsNow()}, {32'h3, 5'b10000});

    // R11: reset in mid-run clears everything
    @(negedge clk); rstN = 1'b0;
    @(negedge clk);
    check({outValid, outResult, flagsNow()} == '0, "R11",
          {26'd0, outValid, outResult, flagsNow()}, 64'd0);

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (TIMEOUT) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", nChecks, nFails);
      $finish;
    end
  end

endmodule